// File: doc/BRIEF.md
# Multi-Channel Edge-Aligned PWM Timer

This block is a timer with one free-running up-counter and a parameterised number of compare channels. All channels share one period. Each channel turns its own compare value into an edge-aligned pulse-width-modulated output, with normal or inverted polarity. Software programs the block through a small register bus. Writes take one clock edge, and reads return the addressed register combinationally. A read-only register reports how many channels the instance was built with. The count can range from two up to a fixed maximum of four.

The counter runs from zero up to the period value and then wraps to zero, so one period lasts period+1 clocks. New period and compare values are held as shadows. They move into the working copies at the next wrap, or at once while the counter is stopped, so the outputs never show a shortened or glitched period. Each channel raises a sticky match flag whenever the running counter equals its working compare value. Software clears the flag by writing one to it.

Top module: `pwm_timer_top`

## Requirements
- R1: While reset is asserted and after it is released, every register reads zero except the channel-count register. All PWM outputs are low, and the counter is stopped.
- R2: The count-mode field is bits [1:0] at address 0. Any nonzero value runs the counter. Zero stops the counter and returns it to 0. While the counter is stopped, an active channel holds its idle level: high for normal polarity, low for inverted polarity.
- R3: While running, the counter steps from 0 to the working period value and then wraps to 0. A PWM output therefore repeats every period+1 clocks.
- R4: A channel is active when its mode bits are 2'b10 (channel register bits [2:1]) and bit 2 of address 0 is 0. With polarity bits [4:3] = 2'b10 (normal) and the counter running, the output is high in the cycle after any cycle in which the counter is below the working compare value. Otherwise it is low.
- R5: With polarity 2'b01 (inverted), the output is the complement of the normal-polarity output under the same conditions.
- R6: In normal polarity, a working compare value above the period value gives a constantly high output, and a compare value of 0 gives a constantly low output.
- R7: A channel drives its output low whenever it is not active. This covers polarity 2'b00 or 2'b11, mode bits other than 2'b10, and the center-select bit (address 0, bit 2) set to 1.
- R8: The period (address 1) and compare (channel n: address 9+2n) registers read back the last written value. That value takes effect only at the next counter wrap, or in the next cycle while the counter is stopped.
- R9: The match flag (bit 0 of channel n's register at address 8+2n) sets when the running counter equals that channel's working compare value, whatever the channel's mode. Writing 1 to bit 0 clears it.
- R10: Address 2 reads the number of implemented channels. Addresses of channels at or above that count read zero, and writes to them are ignored.
- R11: Writing a channel register with bit 0 at 0 updates the mode and polarity bits but leaves the match flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the addressed register |
| pwm_out | output | NUM_CH | PWM output per channel |

## Verification
A counter that wraps at the wrong value shows on every active output within one period, as a wrong interval between rising edges. A working compare copy that loads too early or too late changes the pulse width within one or two periods after a compare write. A wrong match flag appears on the very next read of the channel register. A channel that wrongly treats itself as active drives its output high within one clock of the configuration write, so every output is compared against an expected value in every clock.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int unsigned MAX_CH = 4;
  localparam int unsigned AW     = 4;

  localparam logic [AW-1:0] ADR_GCTL = 4'd0;
  localparam logic [AW-1:0] ADR_PER  = 4'd1;
  localparam logic [AW-1:0] ADR_NCH  = 4'd2;
  localparam int unsigned   ADR_CH0  = 8;

  localparam logic [1:0] MODE_EDGE_PWM = 2'b10;
  localparam logic [1:0] POL_NORMAL    = 2'b10;
  localparam logic [1:0] POL_INVERT    = 2'b01;

  typedef struct packed {
    logic [1:0] pol;
    logic [1:0] mode;
  } ch_cfg_t;
endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] per_shadow,
  output logic [CW-1:0] cnt_o,
  output logic          load_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] per_q, per_d;
  logic          wrap;

  always_comb begin
    wrap   = run && (cnt_q == per_q);
    load_o = !run || wrap;
    cnt_d  = load_o ? '0 : cnt_q + 1'b1;
    per_d  = load_o ? per_shadow : per_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

  assign cnt_o = cnt_q;

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_q);
  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q == per_q) |=> (cnt_q == '0));
  // R2
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
  import pwmt_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          center,
  input  logic [CW-1:0] cnt,
  input  logic          load,
  input  logic          cfg_we,
  input  ch_cfg_t       cfg_wdata,
  input  logic          flag_clr,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  output ch_cfg_t       cfg_o,
  output logic [CW-1:0] cmp_o,
  output logic          flag_o,
  output logic          pwm_o
);
  ch_cfg_t       cfg_q, cfg_d;
  logic [CW-1:0] cmp_sh_q, cmp_sh_d;
  logic [CW-1:0] cmp_act_q, cmp_act_d;
  logic          flag_q, flag_d;
  logic          out_q, out_d;
  logic          active, hit, level;

  always_comb begin
    active = !center && (cfg_q.mode == MODE_EDGE_PWM) &&
             ((cfg_q.pol == POL_NORMAL) || (cfg_q.pol == POL_INVERT));
    hit    = run && (cnt == cmp_act_q);
    level  = run ? (cnt < cmp_act_q) : 1'b1;
    out_d  = active && ((cfg_q.pol == POL_NORMAL) ? level : !level);

    cfg_d     = cfg_we ? cfg_wdata : cfg_q;
    cmp_sh_d  = cmp_we ? cmp_wdata : cmp_sh_q;
    cmp_act_d = load ? cmp_sh_q : cmp_act_q;

    if (hit)           flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      cmp_sh_q  <= '0;
      cmp_act_q <= '0;
      flag_q    <= 1'b0;
      out_q     <= 1'b0;
    end else begin
      cfg_q     <= cfg_d;
      cmp_sh_q  <= cmp_sh_d;
      cmp_act_q <= cmp_act_d;
      flag_q    <= flag_d;
      out_q     <= out_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign cmp_o  = cmp_sh_q;
  assign flag_o = flag_q;
  assign pwm_o  = out_q;

  // R9
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == cmp_act_q) |=> flag_q);
  // R7
  inactive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !out_q);
  // R8
  cmp_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cmp_act_q));
endmodule

// File: rtl/pwmt_regif.sv
module pwmt_regif
  import pwmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CW     = 16,
  parameter int unsigned DW     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                addr,
  input  logic [DW-1:0]                wdata,
  output logic [DW-1:0]                rdata,
  output logic                         run,
  output logic                         center,
  output logic [CW-1:0]                per_shadow,
  output logic [NUM_CH-1:0]            cfg_we,
  output logic [NUM_CH-1:0]            cmp_we,
  output logic [NUM_CH-1:0]            flag_clr,
  input  ch_cfg_t [NUM_CH-1:0]         cfg_i,
  input  logic [NUM_CH-1:0][CW-1:0]    cmp_i,
  input  logic [NUM_CH-1:0]            flag_i
);
  logic [1:0]    cmode_q, cmode_d;
  logic          center_q, center_d;
  logic [CW-1:0] per_q, per_d;
  logic          gctl_we, per_we;

  always_comb begin
    gctl_we  = wr_en && (addr == ADR_GCTL);
    per_we   = wr_en && (addr == ADR_PER);
    cmode_d  = gctl_we ? wdata[1:0] : cmode_q;
    center_d = gctl_we ? wdata[2]   : center_q;
    per_d    = per_we  ? wdata[CW-1:0] : per_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmode_q  <= '0;
      center_q <= 1'b0;
      per_q    <= '0;
    end else begin
      cmode_q  <= cmode_d;
      center_q <= center_d;
      per_q    <= per_d;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    localparam logic [AW-1:0] A_CTL = AW'(ADR_CH0 + 2 * i);
    localparam logic [AW-1:0] A_CMP = AW'(ADR_CH0 + 2 * i + 1);
    assign cfg_we[i]   = wr_en && (addr == A_CTL);
    assign flag_clr[i] = wr_en && (addr == A_CTL) && wdata[0];
    assign cmp_we[i]   = wr_en && (addr == A_CMP);
  end

  always_comb begin
    rdata = '0;
    if (addr == ADR_GCTL)      rdata[2:0] = {center_q, cmode_q};
    else if (addr == ADR_PER)  rdata[CW-1:0] = per_q;
    else if (addr == ADR_NCH)  rdata = DW'(NUM_CH);
    else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr == AW'(ADR_CH0 + 2 * i))     rdata[4:0]    = {cfg_i[i], flag_i[i]};
        if (addr == AW'(ADR_CH0 + 2 * i + 1)) rdata[CW-1:0] = cmp_i[i];
      end
    end
  end

  assign run        = |cmode_q;
  assign center     = center_q;
  assign per_shadow = per_q;

  // R2
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_GCTL) |=> (run == (|$past(wdata[1:0]))));
  // R8
  per_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_PER) |=> (per_shadow == $past(wdata[CW-1:0])));
endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top
  import pwmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CW     = 16,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic                      run, center, load;
  logic [CW-1:0]             per_shadow, cnt;
  logic [NUM_CH-1:0]         cfg_we, cmp_we, flag_clr, flag;
  ch_cfg_t [NUM_CH-1:0]      cfg;
  logic [NUM_CH-1:0][CW-1:0] cmp;

  pwmt_regif #(.NUM_CH(NUM_CH), .CW(CW), .DW(DW)) u_regif (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_en      (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .rdata      (bus_rdata),
    .run        (run),
    .center     (center),
    .per_shadow (per_shadow),
    .cfg_we     (cfg_we),
    .cmp_we     (cmp_we),
    .flag_clr   (flag_clr),
    .cfg_i      (cfg),
    .cmp_i      (cmp),
    .flag_i     (flag)
  );

  pwmt_counter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .run        (run),
    .per_shadow (per_shadow),
    .cnt_o      (cnt),
    .load_o     (load)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwmt_channel #(.CW(CW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .run       (run),
      .center    (center),
      .cnt       (cnt),
      .load      (load),
      .cfg_we    (cfg_we[i]),
      .cfg_wdata (ch_cfg_t'(bus_wdata[4:1])),
      .flag_clr  (flag_clr[i]),
      .cmp_we    (cmp_we[i]),
      .cmp_wdata (bus_wdata[CW-1:0]),
      .cfg_o     (cfg[i]),
      .cmp_o     (cmp[i]),
      .flag_o    (flag[i]),
      .pwm_o     (pwm_out[i])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_core_n |=> (pwm_out == '0));
endmodule

// File: tb/pwm_timer_top_tb_top.sv
module pwm_timer_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int CW  = 16;
  localparam int DW  = 32;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           bus_wr;
  logic [3:0]     bus_addr;
  logic [DW-1:0]  bus_wdata;
  logic [DW-1:0]  bus_rdata;
  logic [NCH-1:0] pwm_out;

  int    n_chk  = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_timer_top #(.NUM_CH(NCH), .CW(CW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // reference model built from the requirements
  logic [1:0]     m_cmode;
  logic           m_center;
  logic [CW-1:0]  m_per_sh, m_per_act, m_cnt;
  logic [1:0]     m_mode [NCH];
  logic [1:0]     m_pol  [NCH];
  logic [CW-1:0]  m_cmp_sh [NCH];
  logic [CW-1:0]  m_cmp_act[NCH];
  logic           m_flag [NCH];
  logic [NCH-1:0] m_out;
  logic [NCH-1:0] exp_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmode <= '0; m_center <= 1'b0; m_per_sh <= '0; m_per_act <= '0;
      m_cnt <= '0; m_out <= '0;
      for (int i = 0; i < NCH; i++) begin
        m_mode[i] <= '0; m_pol[i] <= '0; m_cmp_sh[i] <= '0;
        m_cmp_act[i] <= '0; m_flag[i] <= 1'b0;
      end
    end else begin
      automatic logic run  = (m_cmode != 2'b00);
      automatic logic wrap = run && (m_cnt == m_per_act);
      automatic logic ld   = !run || wrap;
      for (int i = 0; i < NCH; i++) begin
        automatic logic good = !m_center && m_mode[i] == 2'b10 &&
                               (m_pol[i] == 2'b10 || m_pol[i] == 2'b01);
        automatic logic hi = run ? (m_cnt < m_cmp_act[i]) : 1'b1;
        m_out[i] <= good && ((m_pol[i] == 2'b10) ? hi : !hi);
        if (run && m_cnt == m_cmp_act[i]) m_flag[i] <= 1'b1;
        else if (bus_wr && bus_addr == 4'(8 + 2*i) && bus_wdata[0]) m_flag[i] <= 1'b0;
        if (bus_wr && bus_addr == 4'(8 + 2*i)) begin
          m_mode[i] <= bus_wdata[2:1];
          m_pol[i]  <= bus_wdata[4:3];
        end
        if (bus_wr && bus_addr == 4'(9 + 2*i)) m_cmp_sh[i] <= bus_wdata[CW-1:0];
        if (ld) m_cmp_act[i] <= m_cmp_sh[i];
      end
      m_cnt <= ld ? '0 : m_cnt + 1'b1;
      if (ld) m_per_act <= m_per_sh;
      if (bus_wr && bus_addr == 4'd0) begin
        m_cmode  <= bus_wdata[1:0];
        m_center <= bus_wdata[2];
      end
      if (bus_wr && bus_addr == 4'd1) m_per_sh <= bus_wdata[CW-1:0];
    end
  end

  // driver side of the scoreboard: expected output after every edge
  always @(posedge clk) begin
    #1;
    if (rst_n) exp_q.push_back(m_out);
  end

  // monitor side: pop and compare away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      automatic logic [NCH-1:0] e = exp_q.pop_front();
      n_chk++;
      if (pwm_out !== e) begin
        n_fail++;
        $display("FAIL %s: pwm_out=%b expected %b", cur_req, pwm_out, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [DW-1:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    n_chk++;
    if (bus_rdata !== e) begin
      n_fail++;
      $display("FAIL %s: read addr %0d = %h expected %h", tag, a, bus_rdata, e);
    end
  endtask

  task automatic out_chk(input logic [NCH-1:0] mask, input logic [NCH-1:0] e,
                         input int cycles, input string tag);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      #1;
      n_chk++;
      if ((pwm_out & mask) !== (e & mask)) begin
        n_fail++;
        $display("FAIL %s: pwm_out=%b expected %b (mask %b)", tag, pwm_out, e, mask);
      end
    end
  endtask

  task automatic period_chk(input int expect_len, input string tag);
    int len = 0;
    logic prev = pwm_out[0];
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (!prev && pwm_out[0]) break;
      prev = pwm_out[0];
    end
    prev = pwm_out[0];
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      len++;
      if (!prev && pwm_out[0]) break;
      prev = pwm_out[0];
    end
    n_chk++;
    if (len != expect_len) begin
      n_fail++;
      $display("FAIL %s: period %0d expected %0d", tag, len, expect_len);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    out_chk('1, '0, 2, "R1");
    rd_chk(4'd0, 32'h0, "R1");
    rd_chk(4'd1, 32'h0, "R1");
    rd_chk(4'd8, 32'h0, "R1");
    rd_chk(4'd9, 32'h0, "R1");
    rd_chk(4'd2, 32'(NCH), "R10");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk(4'd0, 32'h0, "R1");

    // R2 idle levels while stopped
    cur_req = "R2";
    wr(4'd1, 32'd9);
    wr(4'd9, 32'd4);
    wr(4'd11, 32'd7);
    wr(4'd13, 32'd12);
    wr(4'd8, 32'h14);
    wr(4'd10, 32'h0C);
    wr(4'd12, 32'h14);
    repeat (3) @(negedge clk);
    out_chk('1, 3'b101, 3, "R2");

    // R4 R5 R6 running, R3 period
    cur_req = "R4 R5 R6";
    wr(4'd0, 32'd1);
    repeat (40) @(negedge clk);
    period_chk(10, "R3");
    rd_chk(4'd8, 32'h15, "R9");
    rd_chk(4'd1, 32'd9, "R8");

    // R2 stop returns idle levels
    cur_req = "R2";
    wr(4'd0, 32'd0);
    repeat (2) @(negedge clk);
    out_chk('1, 3'b101, 3, "R2");

    // R11 write without clear keeps flag, R9 write-one clears
    wr(4'd8, 32'h14);
    rd_chk(4'd8, 32'h15, "R11");
    wr(4'd8, 32'h15);
    rd_chk(4'd8, 32'h14, "R9");

    // R8 deferred period and compare update, other nonzero mode runs
    cur_req = "R8";
    wr(4'd0, 32'd3);
    repeat (7) @(negedge clk);
    wr(4'd1, 32'd5);
    wr(4'd9, 32'd0);
    rd_chk(4'd1, 32'd5, "R8");
    rd_chk(4'd9, 32'd0, "R8");
    repeat (30) @(negedge clk);
    cur_req = "R6";
    out_chk(3'b101, 3'b100, 12, "R6");

    // R7 disabled and reserved settings drive low; flag still sets
    cur_req = "R7";
    wr(4'd11, 32'd3);
    wr(4'd10, 32'h03);
    repeat (14) @(negedge clk);
    out_chk(3'b010, 3'b000, 12, "R7");
    rd_chk(4'd10, 32'h03, "R9");
    wr(4'd10, 32'h1C);
    repeat (2) @(negedge clk);
    out_chk(3'b010, 3'b000, 12, "R7");
    wr(4'd10, 32'h01);
    repeat (2) @(negedge clk);
    out_chk(3'b010, 3'b000, 8, "R7");
    wr(4'd0, 32'h5);
    repeat (2) @(negedge clk);
    out_chk('1, 3'b000, 12, "R7");

    // R10 unimplemented channel
    cur_req = "R10";
    wr(4'd14, 32'h15);
    wr(4'd15, 32'h7);
    rd_chk(4'd14, 32'h0, "R10");
    rd_chk(4'd15, 32'h0, "R10");
    rd_chk(4'd2, 32'(NCH), "R10");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule